// File: doc/BRIEF.md
# Segment Access Guard

This block sits in front of address translation. Each cycle it may take one memory access: an address, a byte count, and flags that say whether the access is a write or an instruction fetch. It also takes the attributes of the segment the access uses (readable, writable, grows downward), that segment's base and limit, and the core's mode bits: protection enabled, long mode active, code segment in long mode, and paging enabled.

It decides whether the access raises a general-protection fault. A fault always carries error code zero. If there is no fault, the block decides whether the address goes to the page-translation lookup or is used directly as the physical address.

Segment checks run only when protection is on and the core is outside 64-bit mode. The limit check handles segments that grow upward and segments that grow downward. In both cases it also handles a wrapped segment, where the limit sits below the base. The verdict is registered and appears one clock after the access is presented.

Top module: `seg_guard`

## Requirements
- R1: A response (`rsp_valid`=1) appears exactly one cycle after each cycle with `req_valid`=1; a cycle without a request gives `rsp_valid`=0 on the next cycle.
- R2: Segment checks are skipped (no fault, `rsp_cause`=0) when `prot_en`=0, or when both `long_act`=1 and `cs_long`=1; with `long_act`=1 and `cs_long`=0 they apply.
- R3: A write (`req_wr`=1) to a segment with `seg_wr_ok`=0 faults with `rsp_cause`=2'b01.
- R4: A data read (`req_wr`=0, `req_ex`=0) to a segment with `seg_rd_ok`=0 faults with `rsp_cause`=2'b10; an instruction fetch is not checked for readability.
- R5: Upward segment with limit >= base: a fault with `rsp_cause`=2'b11 occurs when limit < addr+size.
- R6: Upward segment with limit < base: a limit fault occurs only when limit < addr+size and addr < base.
- R7: Downward segment (`seg_down`=1) with limit >= base: a limit fault occurs when addr <= limit and addr+size >= base.
- R8: Downward segment with limit < base: a limit fault occurs when addr <= limit or addr+size >= base.
- R9: A write fault outranks a read fault, and either of them outranks a limit fault in `rsp_cause`.
- R10: Without a fault, `rsp_to_tlb`=1 exactly when `prot_en`=1 and `page_en`=1; `rsp_addr` always equals the request address.
- R11: On a fault, `rsp_gp`=1, `rsp_code`=0 and `rsp_to_tlb`=0.
- R12: The sum addr+size is formed one bit wider than the address, so an access that crosses the top of the address space faults against a limit of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | AW | Access address, segment base already applied |
| req_size | input | SW | Access size in bytes |
| req_wr | input | 1 | Access is a write |
| req_ex | input | 1 | Access is an instruction fetch |
| seg_rd_ok | input | 1 | Segment allows reads |
| seg_wr_ok | input | 1 | Segment allows writes |
| seg_down | input | 1 | Segment grows downward |
| seg_base | input | AW | Segment base |
| seg_limit | input | AW | Segment limit |
| prot_en | input | 1 | Protection enabled |
| long_act | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is a long-mode segment |
| page_en | input | 1 | Paging enabled |
| rsp_valid | output | 1 | Verdict valid |
| rsp_gp | output | 1 | General-protection fault |
| rsp_code | output | 16 | Fault error code (always zero) |
| rsp_cause | output | 2 | 00 pass, 01 write denied, 10 read denied, 11 limit |
| rsp_to_tlb | output | 1 | Route address to page translation |
| rsp_addr | output | AW | Address forwarded |

## Verification
Every verdict field comes from one register stage. All of them are therefore due on the first rising edge after the access is held on the inputs. The bench drives each access on a falling edge and lets a single rising edge pass. It reads the outputs on the following falling edge, half a period after they change. Idle cycles between scenarios show that `rsp_valid` drops in the cycle after a cycle with no request.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size,
  input  logic          req_wr,
  input  logic          req_ex,
  input  logic          seg_rd_ok,
  input  logic          seg_wr_ok,
  input  logic          seg_down,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_limit,
  input  logic          prot_en,
  input  logic          long_act,
  input  logic          cs_long,
  input  logic          page_en,
  output logic          rsp_valid,
  output logic          rsp_gp,
  output logic [15:0]   rsp_code,
  output logic [1:0]    rsp_cause,
  output logic          rsp_to_tlb,
  output logic [AW-1:0] rsp_addr
);
  localparam int EW = AW + 1;

  logic [EW-1:0] addr_x, base_x, lim_x, end_x;
  logic chk_on, wrapped, lim_bad, wr_bad, rd_bad, fault;
  logic up_bad, down_bad;
  logic [1:0] cause;

  assign chk_on  = prot_en & ~(long_act & cs_long);
  assign addr_x  = {1'b0, req_addr};
  assign base_x  = {1'b0, seg_base};
  assign lim_x   = {1'b0, seg_limit};
  assign end_x   = addr_x + EW'(req_size);
  assign wrapped = lim_x < base_x;

  assign up_bad   = wrapped ? ((lim_x < end_x) & (addr_x < base_x))
                            : (lim_x < end_x);
  assign down_bad = wrapped ? ((addr_x <= lim_x) | (end_x >= base_x))
                            : ((addr_x <= lim_x) & (end_x >= base_x));
  assign lim_bad  = seg_down ? down_bad : up_bad;

  assign wr_bad = req_wr & ~seg_wr_ok;
  assign rd_bad = ~req_wr & ~req_ex & ~seg_rd_ok;

  always_comb begin
    cause = 2'b00;
    if (chk_on) begin
      if (wr_bad)       cause = 2'b01;
      else if (rd_bad)  cause = 2'b10;
      else if (lim_bad) cause = 2'b11;
    end
  end

  assign fault = cause != 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_gp     <= 1'b0;
      rsp_cause  <= 2'b00;
      rsp_to_tlb <= 1'b0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_gp     <= fault;
        rsp_cause  <= cause;
        rsp_to_tlb <= ~fault & prot_en & page_en;
        rsp_addr   <= req_addr;
      end
    end
  end

  assign rsp_code = 16'h0000;
endmodule

module seg_guard_chk #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_wr,
  input logic          seg_wr_ok,
  input logic          prot_en,
  input logic          long_act,
  input logic          cs_long,
  input logic          rsp_valid,
  input logic          rsp_gp,
  input logic [1:0]    rsp_cause,
  input logic          rsp_to_tlb,
  input logic [AW-1:0] rsp_addr
);
  // R1
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (!prot_en || (long_act && cs_long)) |=> !rsp_gp && rsp_cause == 2'b00);
  // R3
  wr_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && prot_en && !(long_act && cs_long) && req_wr && !seg_wr_ok
      |=> rsp_gp && rsp_cause == 2'b01);
  // R10
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_addr == $past(req_addr));
  // R10
  real_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !prot_en |=> !rsp_to_tlb);
  // R11
  fault_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_gp |-> !rsp_to_tlb && rsp_cause != 2'b00);
endmodule

bind seg_guard seg_guard_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_wr(req_wr), .seg_wr_ok(seg_wr_ok), .prot_en(prot_en),
  .long_act(long_act), .cs_long(cs_long), .rsp_valid(rsp_valid),
  .rsp_gp(rsp_gp), .rsp_cause(rsp_cause), .rsp_to_tlb(rsp_to_tlb),
  .rsp_addr(rsp_addr));

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wr = 0, req_ex = 0;
  logic [31:0] req_addr = 0, seg_base = 0, seg_limit = 0;
  logic [3:0] req_size = 0;
  logic seg_rd_ok = 1, seg_wr_ok = 1, seg_down = 0;
  logic prot_en = 1, long_act = 0, cs_long = 0, page_en = 0;
  logic rsp_valid, rsp_gp, rsp_to_tlb;
  logic [15:0] rsp_code;
  logic [1:0] rsp_cause;
  logic [31:0] rsp_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_guard u_seg_guard (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go(logic [31:0] a, logic [3:0] sz, logic w, logic x);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_wr = w; req_ex = x;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_v(string tag, logic gp, logic [1:0] cause, logic tlb, logic [31:0] a);
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " gp"}, rsp_gp, gp);
    chk({tag, " cause"}, rsp_cause, cause);
    chk({tag, " tlb"}, rsp_to_tlb, tlb);
    chk({tag, " addr"}, rsp_addr, a);
    if (gp) chk({tag, " code"}, rsp_code, 0);
  endtask

  task automatic seg(logic rd, logic wr, logic dn, logic [31:0] b, logic [31:0] l);
    seg_rd_ok = rd; seg_wr_ok = wr; seg_down = dn; seg_base = b; seg_limit = l;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", rsp_valid, 0);
    chk("R11 reset gp", rsp_gp, 0);
    chk("R10 reset tlb", rsp_to_tlb, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R1 idle", rsp_valid, 0);
  endtask

  task automatic t_bypass();
    seg(1, 0, 0, 32'h1000, 32'h1FFF);
    prot_en = 0; page_en = 1;
    go(32'h5000, 4, 1, 0); expect_v("R2 prot off", 0, 0, 0, 32'h5000);
    prot_en = 1; long_act = 1; cs_long = 1;
    go(32'h5000, 4, 1, 0); expect_v("R2 64bit", 0, 0, 1, 32'h5000);
    cs_long = 0;
    go(32'h5000, 4, 1, 0); expect_v("R2 compat", 1, 1, 0, 32'h5000);
    long_act = 0; page_en = 0;
  endtask

  task automatic t_attr();
    seg(0, 0, 0, 32'h0, 32'hFFFF);
    go(32'h100, 4, 1, 0); expect_v("R3 write denied", 1, 1, 0, 32'h100);
    go(32'h100, 4, 0, 0); expect_v("R4 read denied", 1, 2, 0, 32'h100);
    go(32'h100, 4, 0, 1); expect_v("R4 fetch ok", 0, 0, 0, 32'h100);
    seg(1, 1, 0, 32'h0, 32'hFFFF);
    go(32'h100, 4, 1, 0); expect_v("R3 write ok", 0, 0, 0, 32'h100);
  endtask

  task automatic t_up();
    seg(1, 1, 0, 32'h1000, 32'h1FFF);
    go(32'h1FFC, 3, 0, 0); expect_v("R5 edge in", 0, 0, 0, 32'h1FFC);
    go(32'h1FFC, 4, 0, 0); expect_v("R5 edge out", 1, 3, 0, 32'h1FFC);
    seg(1, 1, 0, 32'h8000, 32'h1000);
    go(32'h0800, 4, 0, 0); expect_v("R6 low ok", 0, 0, 0, 32'h0800);
    go(32'h2000, 4, 0, 0); expect_v("R6 gap", 1, 3, 0, 32'h2000);
    go(32'h9000, 4, 0, 0); expect_v("R6 high ok", 0, 0, 0, 32'h9000);
  endtask

  task automatic t_down();
    seg(1, 1, 1, 32'h1000, 32'h3000);
    go(32'h2000, 4, 0, 0); expect_v("R7 both", 1, 3, 0, 32'h2000);
    go(32'h4000, 4, 0, 0); expect_v("R7 above", 0, 0, 0, 32'h4000);
    go(32'h0800, 4, 0, 0); expect_v("R7 below base", 0, 0, 0, 32'h0800);
    seg(1, 1, 1, 32'h8000, 32'h1000);
    go(32'h0800, 4, 0, 0); expect_v("R8 at limit", 1, 3, 0, 32'h0800);
    go(32'h7FF0, 4, 0, 0); expect_v("R8 between", 0, 0, 0, 32'h7FF0);
    go(32'h7FFC, 4, 0, 0); expect_v("R8 reach base", 1, 3, 0, 32'h7FFC);
  endtask

  task automatic t_prio();
    seg(0, 0, 0, 32'h1000, 32'h1FFF);
    go(32'h3000, 4, 1, 0); expect_v("R9 wr over limit", 1, 1, 0, 32'h3000);
    go(32'h3000, 4, 0, 0); expect_v("R9 rd over limit", 1, 2, 0, 32'h3000);
  endtask

  task automatic t_route();
    seg(1, 1, 0, 32'h0, 32'hFFFF);
    page_en = 1;
    go(32'h1234, 2, 0, 0); expect_v("R10 paged", 0, 0, 1, 32'h1234);
    go(32'h20000, 2, 0, 0); expect_v("R11 fault no tlb", 1, 3, 0, 32'h20000);
    page_en = 0;
    go(32'h1234, 2, 0, 0); expect_v("R10 flat", 0, 0, 0, 32'h1234);
  endtask

  task automatic t_wide();
    seg(1, 1, 0, 32'h0, 32'hFFFF_FFFF);
    go(32'hFFFF_FFF0, 4, 0, 0); expect_v("R12 near top", 0, 0, 0, 32'hFFFF_FFF0);
    go(32'hFFFF_FFFE, 4, 0, 0); expect_v("R12 crosses top", 1, 3, 0, 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_bypass();
    t_idle();
    t_attr();
    t_up();
    t_down();
    t_prio();
    t_route();
    t_wide();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule